// File: doc/BRIEF.md
# Serial Flash Write Sequencer

This block sits on the host side of a serial NOR flash and turns one request into the full SPI command sequence for a page program, a sector erase or a bulk erase. Each request carries an operation code, a 24-bit start address and a byte count. A page program also carries a byte stream, which the block takes one byte at a time through a valid/ready pair.

For every program or erase step, the block first sends a write-enable command in a chip-select frame of its own. It then sends the command frame itself. After that it keeps issuing single-byte status reads, each in its own frame, until the busy flag reads clear. A page program that runs past a page boundary is cut into page-sized segments. Each segment gets its own write-enable, program frame and polling loop.

The block answers every request with a one-cycle response that carries a result code. A status read that stays busy for the programmed number of reads ends the request with a timeout code. Every bit to be programmed must already be in the erased state (FFh). The block never checks this; it is the caller's task to erase first.

Top module: `flash_write_seq`

## Requirements
- R1: Every page program, sector erase and bulk erase frame is preceded by a frame that holds only the write-enable byte 06h.
- R2: A page program frame carries 02h, then the current address as three bytes (bits 23:16 first), then the data bytes. Bits go out MSB first in SPI mode 0: SCK rests low, and MOSI stays stable while SCK is high.
- R3: No program frame crosses a page boundary. Each segment carries min(remaining, PAGE_BYTES − address mod PAGE_BYTES) bytes, and each segment gets its own write-enable, program frame and polling.
- R4: After each program or erase frame, the block sends status-read frames (05h followed by one read byte) until bit 0 of the returned byte is 0. It then starts the next segment or responds with code 0 (ok).
- R5: If cfg_poll_limit status reads in a row return bit 0 set, the request ends with code 2 (timeout) and no further frame is sent for it. A ready reading on exactly the last allowed read still ends with code 0.
- R6: A page program request (req_op 0) with req_len 0 gets code 1 on rsp_valid the cycle after it is accepted, with no chip-select activity.
- R7: A sector erase (req_op 1) sends D8h plus three address bytes. A bulk erase (req_op 2 or 3) sends C7h alone. Both are polled, and both ignore req_len, including a value of 0.
- R8: Between any two frames, chip select stays high for at least 2·SCK_HALF clock cycles, and SCK is low whenever chip select is high.
- R9: wr_ready is asserted only while chip select is low in the data phase. When wr_valid stalls, the frame pauses with SCK low, and the bytes still go out in stream order.
- R10: During and after reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1 and rsp_valid is 0.
- R11: rsp_valid is a single-cycle pulse, and req_ready is high only while no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_poll_limit | input | POLL_W | Consecutive busy status reads allowed before timeout (at least 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_op | input | 2 | 0 page program, 1 sector erase, 2/3 bulk erase |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Byte count for page program |
| wr_valid | input | 1 | Data byte present |
| wr_ready | output | 1 | Data byte taken when valid |
| wr_data | input | 8 | Data byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 ok, 1 empty request, 2 timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that cfg_poll_limit is at least 1 and stays constant while a request is running. They also assume that spi_miso changes only on falling SCK edges, and that a page program's byte stream holds at least req_len bytes. The bench meets these assumptions as follows. Its flash model changes MISO only on falling SCK edges. The data source presents an unlimited stream whose byte values are a function of the target address. The poll limit is changed only between requests, while the block is idle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int ADDR_W = 24;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_PROG = 8'h02;
    localparam logic [7:0] CMD_SECT = 8'hD8;
    localparam logic [7:0] CMD_CHIP = 8'hC7;
    localparam logic [7:0] CMD_STAT = 8'h05;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_CHIP_ALT = 2'd3
    } flash_op_e;

    typedef enum logic [1:0] {
        RC_OK      = 2'd0,
        RC_EMPTY   = 2'd1,
        RC_TIMEOUT = 2'd2
    } resp_code_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_STAT_CMD,
        ST_STAT_RD,
        ST_GAP,
        ST_CHECK,
        ST_RESP
    } seq_state_e;

    function automatic logic is_erase_all(flash_op_e op);
        return (op == OP_CHIP) || (op == OP_CHIP_ALT);
    endfunction

    function automatic logic [7:0] cmd_for(flash_op_e op);
        case (op)
            OP_PROG: return CMD_PROG;
            OP_SECT: return CMD_SECT;
            default: return CMD_CHIP;
        endcase
    endfunction

    function automatic logic [7:0] addr_byte(logic [ADDR_W-1:0] a, logic [1:0] idx);
        case (idx)
            2'd0:    return a[23:16];
            2'd1:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

    function automatic logic in_frame(seq_state_e s);
        return (s == ST_WREN) || (s == ST_CMD) || (s == ST_ADDR) ||
               (s == ST_DATA) || (s == ST_STAT_CMD) || (s == ST_STAT_RD);
    endfunction

endpackage

// File: rtl/fw_spi_byte.sv
module fw_spi_byte #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       idle,
    output logic       done,
    output logic       rx_last
);
    localparam int DIV_W = $clog2(SCK_HALF) + 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(SCK_HALF - 1);

    logic             active_q;
    logic             high_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       sh_q;
    logic             sck_q;
    logic             done_q;
    logic             rx_q;
    logic             tick;

    assign tick = (div_q == DIV_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            high_q   <= 1'b0;
            bit_q    <= '0;
            div_q    <= '0;
            sh_q     <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            rx_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx;
                    bit_q    <= '0;
                    high_q   <= 1'b0;
                    div_q    <= '0;
                end
            end else begin
                div_q <= tick ? '0 : div_q + 1'b1;
                if (tick) begin
                    if (!high_q) begin
                        sck_q  <= 1'b1;
                        high_q <= 1'b1;
                        rx_q   <= miso;
                    end else begin
                        sck_q  <= 1'b0;
                        high_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh_q[7];
    assign idle    = !active_q;
    assign done    = done_q;
    assign rx_last = rx_q;

endmodule

// File: rtl/fw_seg_len.sv
module fw_seg_len #(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 16
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
    input  logic [LEN_W-1:0]              remain,
    output logic [LEN_W-1:0]              seg
);
    localparam int PB = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    always_comb begin
        room = LEN_W'(PAGE_BYTES) - {{(LEN_W-PB){1'b0}}, page_off};
        seg  = (remain < room) ? remain : room;
    end

endmodule

// File: rtl/fw_poll_count.sv
module fw_poll_count #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    input  logic [POLL_W-1:0] limit,
    output logic              expired
);
    logic [POLL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/flash_write_seq.sv
module flash_write_seq
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 16,
    parameter int POLL_W     = 16,
    parameter int SCK_HALF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [POLL_W-1:0] cfg_poll_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PB      = $clog2(PAGE_BYTES);
    localparam int GAP_CYC = 2 * SCK_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    seq_state_e         st_q, st_d, ret_q, ret_d;
    resp_code_e         code_q, code_d;
    flash_op_e          op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   rem_q;
    logic [LEN_W-1:0]   seg_q;
    logic [LEN_W-1:0]   seg_len;
    logic [1:0]         idx_q;
    logic [GAP_W-1:0]   gap_q;
    logic               pend_q;
    logic               busy_q;
    logic               cs_n_q;

    logic               sh_idle, sh_done, sh_rx, sh_start;
    logic [7:0]         sh_tx;
    logic               byte_state, can_launch;
    logic               poll_clr, poll_inc, poll_expired;

    fw_spi_byte #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx      (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .idle    (sh_idle),
        .done    (sh_done),
        .rx_last (sh_rx)
    );

    fw_seg_len #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_seg (
        .page_off (addr_q[PB-1:0]),
        .remain   (rem_q),
        .seg      (seg_len)
    );

    fw_poll_count #(.POLL_W(POLL_W)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .clr     (poll_clr),
        .inc     (poll_inc),
        .limit   (cfg_poll_limit),
        .expired (poll_expired)
    );

    // byte launch control: one byte in flight at a time
    always_comb begin
        byte_state = in_frame(st_q);
        can_launch = byte_state && sh_idle && !pend_q;
        wr_ready   = (st_q == ST_DATA) && sh_idle && !pend_q;
        sh_start   = can_launch && ((st_q != ST_DATA) || wr_valid);
        case (st_q)
            ST_WREN:     sh_tx = CMD_WREN;
            ST_CMD:      sh_tx = cmd_for(op_q);
            ST_ADDR:     sh_tx = addr_byte(addr_q, idx_q);
            ST_DATA:     sh_tx = wr_data;
            ST_STAT_CMD: sh_tx = CMD_STAT;
            default:     sh_tx = 8'h00;
        endcase
        poll_inc = sh_done && (st_q == ST_STAT_RD);
        poll_clr = (st_q == ST_IDLE) || ((st_q == ST_CHECK) && !busy_q);
    end

    // sequencing
    always_comb begin
        st_d   = st_q;
        ret_d  = ret_q;
        code_d = code_q;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if ((flash_op_e'(req_op) == OP_PROG) && (req_len == '0)) begin
                        st_d   = ST_RESP;
                        code_d = RC_EMPTY;
                    end else begin
                        st_d = ST_WREN;
                    end
                end
            end
            ST_WREN: begin
                if (sh_done) begin
                    st_d  = ST_GAP;
                    ret_d = ST_CMD;
                end
            end
            ST_CMD: begin
                if (sh_done) begin
                    if (is_erase_all(op_q)) begin
                        st_d  = ST_GAP;
                        ret_d = ST_STAT_CMD;
                    end else begin
                        st_d = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (sh_done && (idx_q == 2'd2)) begin
                    if (op_q == OP_PROG) begin
                        st_d = ST_DATA;
                    end else begin
                        st_d  = ST_GAP;
                        ret_d = ST_STAT_CMD;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done && (seg_q == '0)) begin
                    st_d  = ST_GAP;
                    ret_d = ST_STAT_CMD;
                end
            end
            ST_STAT_CMD: begin
                if (sh_done) st_d = ST_STAT_RD;
            end
            ST_STAT_RD: begin
                if (sh_done) begin
                    st_d  = ST_GAP;
                    ret_d = ST_CHECK;
                end
            end
            ST_GAP: begin
                if (gap_q == GAP_W'(GAP_CYC - 1)) st_d = ret_q;
            end
            ST_CHECK: begin
                if (busy_q) begin
                    if (poll_expired) begin
                        st_d   = ST_RESP;
                        code_d = RC_TIMEOUT;
                    end else begin
                        st_d = ST_STAT_CMD;
                    end
                end else if ((op_q == OP_PROG) && (rem_q != '0)) begin
                    st_d = ST_WREN;
                end else begin
                    st_d   = ST_RESP;
                    code_d = RC_OK;
                end
            end
            ST_RESP: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ret_q  <= ST_IDLE;
            code_q <= RC_OK;
            op_q   <= OP_PROG;
            addr_q <= '0;
            rem_q  <= '0;
            seg_q  <= '0;
            idx_q  <= '0;
            gap_q  <= '0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            ret_q  <= ret_d;
            code_q <= code_d;
            cs_n_q <= !in_frame(st_d);

            if ((st_q == ST_IDLE) && req_valid) begin
                op_q   <= flash_op_e'(req_op);
                addr_q <= req_addr;
                rem_q  <= req_len;
            end

            if (sh_start)     pend_q <= 1'b1;
            else if (sh_done) pend_q <= 1'b0;

            if ((st_q == ST_WREN) && sh_done) seg_q <= seg_len;

            if (st_q == ST_CMD)                   idx_q <= '0;
            else if ((st_q == ST_ADDR) && sh_done) idx_q <= idx_q + 2'd1;

            if (sh_start && (st_q == ST_DATA)) begin
                addr_q <= addr_q + 1'b1;
                rem_q  <= rem_q - 1'b1;
                seg_q  <= seg_q - 1'b1;
            end

            gap_q <= (st_q == ST_GAP) ? gap_q + 1'b1 : '0;

            if ((st_q == ST_STAT_RD) && sh_done) busy_q <= sh_rx;
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_valid = (st_q == ST_RESP);
    assign rsp_code  = code_q;
    assign spi_cs_n  = cs_n_q;

endmodule

// File: rtl/flash_write_seq_chk.sv
module flash_write_seq_chk #(
    parameter int SCK_HALF = 2,
    parameter int LEN_W    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [LEN_W-1:0] req_len,
    input logic             wr_ready,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic             spi_cs_n,
    input logic             spi_sck,
    input logic             spi_mosi
);
    localparam int GAP_CYC = 2 * SCK_HALF;

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                hi_cnt <= 16'(GAP_CYC);
        else if (!spi_cs_n)     hi_cnt <= '0;
        else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 16'd1;
    end

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && $past(spi_cs_n)) |-> (hi_cnt >= 16'(GAP_CYC)));

    // R8
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R6
    empty_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_op == 2'd0) && (req_len == '0))
        |=> (rsp_valid && (rsp_code == 2'd1) && spi_cs_n));

    // R9
    data_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !spi_cs_n);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_cs_n && !rsp_valid && !wr_ready));

endmodule

bind flash_write_seq flash_write_seq_chk #(
    .SCK_HALF (SCK_HALF),
    .LEN_W    (LEN_W)
) u_flash_write_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_len   (req_len),
    .wr_ready  (wr_ready),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_flash_write_seq.sv
`timescale 1ns/1ps
module test_flash_write_seq;
    localparam int HALF = 1;
    localparam int PAGE = 16;
    localparam int LW   = 8;
    localparam int PW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] cfg_poll_limit = PW'(20);
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          wr_valid = 1'b1;
    logic          wr_ready;
    logic [7:0]    wr_data;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic          spi_cs_n, spi_sck, spi_mosi;
    logic          spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    flash_write_seq #(.PAGE_BYTES(PAGE), .LEN_W(LW), .POLL_W(PW), .SCK_HALF(HALF))
    i_flash_write_seq (
        .clk(clk), .rst(rst), .cfg_poll_limit(cfg_poll_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // data source: byte value follows target address
    logic [23:0] drv_a = '0;
    bit          stall = 1'b0;
    int          cyc = 0;
    assign wr_data = pat(drv_a);
    always @(posedge clk) if (wr_valid && wr_ready) drv_a <= drv_a + 24'd1;
    always @(negedge clk) begin
        cyc++;
        wr_valid = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    // flash model
    int f_op[0:63];
    int f_addr[0:63];
    int f_nb[0:63];
    int nfr, npoll, wel_viol, data_bad, busy_left, busy_cfg;
    int bits, op_cur, fa;
    bit wel, armed;
    logic [7:0] cur;
    logic [7:0] stat;

    always @(negedge spi_cs_n) begin
        armed = 1'b1; bits = 0; op_cur = -1; fa = 0; cur = '0;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        cur = {cur[6:0], spi_mosi};
        bits++;
        if ((bits % 8) == 0) begin
            if (bits == 8) op_cur = int'(cur);
            else if (bits <= 32) fa = ((fa << 8) | int'(cur)) & 32'hFFFFFF;
            else if (op_cur == 8'h02 && cur != pat(24'(fa + bits / 8 - 5))) data_bad++;
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n && op_cur == 8'h05 && bits >= 8) begin
        stat = {6'b101010, wel, (busy_left > 0)};
        spi_miso = stat[7 - (bits % 8)];
    end

    always @(posedge spi_cs_n) if (armed) begin
        if (op_cur == 8'h05) begin
            npoll++;
            if (busy_left > 0) busy_left--;
        end else begin
            if (nfr < 64) begin
                f_op[nfr] = op_cur; f_addr[nfr] = fa; f_nb[nfr] = bits / 8;
            end
            nfr++;
            if (op_cur == 8'h06) wel = 1'b1;
            else begin
                if (!wel) wel_viol++;
                wel = 1'b0;
                busy_left = busy_cfg;
            end
        end
    end

    // chip-select gap and idle-clock monitor
    int hi_cnt = 100, gap_viol = 0, sck_viol = 0, ncs = 0;
    logic prev_cs = 1'b1;
    always @(negedge clk) if (!rst) begin
        if (spi_cs_n) begin
            hi_cnt++;
            if (spi_sck) sck_viol++;
        end else begin
            if (prev_cs) begin
                ncs++;
                if (hi_cnt < 2 * HALF) gap_viol++;
            end
            hi_cnt = 0;
        end
        prev_cs = spi_cs_n;
    end

    int got_code;

    task automatic run(input int op, input int addr, input int len, input int busy, input int limit);
        nfr = 0; npoll = 0; wel_viol = 0; data_bad = 0; busy_left = 0; wel = 1'b0;
        busy_cfg = busy; gap_viol = 0; sck_viol = 0; ncs = 0;
        cfg_poll_limit = PW'(limit);
        drv_a = 24'(addr);
        req_op = 2'(op); req_addr = 24'(addr); req_len = LW'(len);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_code = int'(rsp_code);
        @(negedge clk);
        // R11
        chk(!rsp_valid && req_ready, "R11", "pulse end / ready", int'(rsp_valid), 0);
    endtask

    task automatic check_prog(input int addr, input int len, input int busy);
        int a = addr, r = len, segs = 0, n;
        bit ok_wren = 1, ok_seg = 1;
        int bad_i = -1;
        while (r > 0) begin
            n = PAGE - (a % PAGE);
            if (r < n) n = r;
            if (f_op[2*segs] != 8'h06 || f_nb[2*segs] != 1) ok_wren = 0;
            if (f_op[2*segs+1] != 8'h02 || f_addr[2*segs+1] != a || f_nb[2*segs+1] != 4 + n) begin
                ok_seg = 0; bad_i = 2*segs+1;
            end
            a += n; r -= n; segs++;
        end
        chk(got_code == 0, "R4", "program result code", got_code, 0);
        chk(nfr == 2 * segs, "R3", "frame count", nfr, 2 * segs);
        chk(ok_wren && wel_viol == 0, "R1", "write-enable before program", wel_viol, 0);
        chk(ok_seg, "R3", "segment address/length", bad_i, -1);
        chk(data_bad == 0, "R2", "data byte values", data_bad, 0);
        chk(npoll == segs * (busy + 1), "R4", "status reads", npoll, segs * (busy + 1));
        chk(gap_viol == 0 && sck_viol == 0, "R8", "cs gap / idle sck", gap_viol + sck_viol, 0);
    endtask

    initial begin
        int lens[5];
        repeat (5) @(negedge clk);
        // R10
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R10", "spi idle in reset", int'(spi_sck), 0);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10", "handshake in reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && req_ready == 1'b1, "R10", "after reset", int'(spi_cs_n), 1);

        // R6: empty program rejected
        run(0, 24'h000123, 0, 0, 20);
        chk(got_code == 1, "R6", "empty code", got_code, 1);
        chk(ncs == 0 && nfr == 0, "R6", "no frames", ncs, 0);

        // R3/R9: sweep of page offsets and lengths
        for (int off = 0; off < PAGE; off++) begin
            lens[0] = 1; lens[1] = PAGE - off; lens[2] = PAGE + 1 - off;
            lens[3] = PAGE; lens[4] = 2 * PAGE + 1;
            for (int k = 0; k < 5; k++) begin
                stall = (off % 2) == 1; // R9 stalled stream on odd offsets
                run(0, 24'h012340 + off, lens[k], off % 3, 20);
                check_prog(24'h012340 + off, lens[k], off % 3);
            end
        end
        stall = 1'b0;

        // R5: timeout on first segment of a split request
        run(0, 24'h00004E, 5, 10, 3);
        chk(got_code == 2, "R5", "timeout code", got_code, 2);
        chk(npoll == 3, "R5", "reads before timeout", npoll, 3);
        chk(nfr == 2, "R5", "no frame after timeout", nfr, 2);

        // R5: ready on the last allowed read
        run(0, 24'h00004E, 5, 2, 3);
        check_prog(24'h00004E, 5, 2);

        // R7: sector erase
        run(1, 24'h055A37, 9, 1, 20);
        chk(got_code == 0, "R7", "sector erase code", got_code, 0);
        chk(nfr == 2 && f_op[0] == 8'h06 && wel_viol == 0, "R1", "erase preceded by enable", nfr, 2);
        chk(f_op[1] == 8'hD8 && f_nb[1] == 4 && f_addr[1] == 24'h055A37, "R7", "sector frame", f_op[1], 8'hD8);
        chk(npoll == 2, "R7", "sector erase reads", npoll, 2);

        // R7: bulk erase with zero count
        run(2, 24'h000000, 0, 3, 20);
        chk(got_code == 0, "R7", "bulk erase code", got_code, 0);
        chk(nfr == 2 && f_op[1] == 8'hC7 && f_nb[1] == 1, "R7", "bulk frame", f_nb[1], 1);
        chk(npoll == 4 && wel_viol == 0, "R7", "bulk erase reads", npoll, 4);
        chk(gap_viol == 0 && sck_viol == 0, "R8", "erase cs gap", gap_viol, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule